// File: doc/BRIEF.md
# Traffic Endpoint Statistics Counter

This block sits at one node of a network simulator and acts both as a traffic source and as a traffic sink. A global simulated-time value and a tick strobe are broadcast to it. Each tick advances simulated time by one cycle. On a fixed schedule the block generates a flit that carries a configured destination and the simulated time at which it was made. It presents the flit to a downstream queue and holds it there while the queue is full.

Flits that arrive for this node are consumed. For each one the block counts the reception and adds to a running sum the flit's latency in simulated time, which is the current time minus the stamp the flit carries. A flit that arrives for another node is flagged as misrouted and is not counted. A host reads the injected count, the received count and the latency sum through a 2-bit select.

Top module: `traffic_endpoint`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, all three counters read 0 and no flit is offered. `clr` also restarts the injection schedule.
- R2: With `cfg_period` = P > 0 and the queue never full, a flit is generated on every P-th tick after reset or clear. It is offered on `inj_valid` from the next cycle, with `inj_dest` equal to `cfg_dest`.
- R3: `inj_stamp` equals the `sim_time` value present on the tick that generated the flit.
- R4: With `cfg_period` = 0, no flit is ever generated and the injected count stays unchanged.
- R5: While `q_full` is high, `inj_valid` is low and the pending flit keeps its stamp. A flit generated while an earlier flit is still pending is dropped. A flit counts as injected only in a cycle where `inj_valid` is high.
- R6: Each cycle with `rx_valid` high and `rx_dest` equal to `node_id` increments the received count by one.
- R7: Each such reception adds (`sim_time` − `rx_stamp`) to the latency sum. For example, stamp 0 received at time 6 adds 6.
- R8: A reception with `rx_dest` not equal to `node_id` raises `rx_misroute` for one cycle on the next cycle. It changes neither the received count nor the latency sum.
- R9: Every counter is `CNT_W` bits wide and saturates at its all-ones value instead of wrapping.
- R10: `rd_data` is combinational from `rd_sel`: 0 gives the injected count, 1 the received count, 2 the latency sum, and 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of the counters and the schedule |
| tick | input | 1 | One simulated cycle elapses in this clock |
| sim_time | input | TIME_W | Global simulated time |
| node_id | input | NODE_W | Address of this node |
| cfg_period | input | PER_W | Ticks between generated flits; 0 turns injection off |
| cfg_dest | input | NODE_W | Destination for generated flits |
| q_full | input | 1 | Downstream queue cannot take a flit |
| inj_valid | output | 1 | A flit is offered and taken this cycle |
| inj_dest | output | NODE_W | Destination of the offered flit |
| inj_stamp | output | TIME_W | Generation time of the offered flit |
| rx_valid | input | 1 | An arriving flit is present |
| rx_dest | input | NODE_W | Destination of the arriving flit |
| rx_stamp | input | TIME_W | Injection stamp of the arriving flit |
| rx_misroute | output | 1 | The previous arrival was for another node |
| rd_sel | input | 2 | Counter select |
| rd_data | output | CNT_W | Selected counter value |

## Verification
The embedded assertions check four rules on every cycle: counters never decrease except under clear, a full queue always blocks the offer while the stamp holds, a disabled schedule never creates a flit, and a misroute leaves the received count untouched. The exact spacing and stamping of generated flits for each period, the dropping of a flit generated while another is pending, the arithmetic value of the latency sum, and saturation of that sum can only be shown by the bench's scenarios. For these the bench compares the outputs against values it computes itself.

// File: rtl/traffic_endpoint.sv
module traffic_endpoint #(
  parameter int NODE_W = 4,
  parameter int TIME_W = 32,
  parameter int PER_W  = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [TIME_W-1:0] sim_time,
  input  logic [NODE_W-1:0] node_id,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic [NODE_W-1:0] cfg_dest,
  input  logic              q_full,
  output logic              inj_valid,
  output logic [NODE_W-1:0] inj_dest,
  output logic [TIME_W-1:0] inj_stamp,
  input  logic              rx_valid,
  input  logic [NODE_W-1:0] rx_dest,
  input  logic [TIME_W-1:0] rx_stamp,
  output logic              rx_misroute,
  input  logic [1:0]        rd_sel,
  output logic [CNT_W-1:0]  rd_data
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [PER_W-1:0]  phase;
  logic              pend;
  logic              gen;
  logic              rx_hit;
  logic [CNT_W-1:0]  cnt_inj, cnt_rx, lat_sum;
  logic [TIME_W-1:0] delta;
  logic [CNT_W:0]    sum_wide;

  assign gen       = tick && (cfg_period != '0) && (phase >= cfg_period - 1'b1);
  assign inj_valid = pend && !q_full;
  assign rx_hit    = rx_valid && (rx_dest == node_id);
  assign delta     = sim_time - rx_stamp;
  assign sum_wide  = {1'b0, lat_sum} + (CNT_W+1)'(delta);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) phase <= '0;
    else if (tick) begin
      if (cfg_period == '0 || gen) phase <= '0;
      else                         phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pend      <= 1'b0;
      inj_stamp <= '0;
      inj_dest  <= '0;
    end else if (gen && (!pend || inj_valid)) begin
      pend      <= 1'b1;
      inj_stamp <= sim_time;
      inj_dest  <= cfg_dest;
    end else if (inj_valid) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_inj     <= '0;
      cnt_rx      <= '0;
      lat_sum     <= '0;
      rx_misroute <= 1'b0;
    end else begin
      rx_misroute <= rx_valid && !rx_hit;
      if (inj_valid && cnt_inj != CMAX) cnt_inj <= cnt_inj + 1'b1;
      if (rx_hit) begin
        if (cnt_rx != CMAX) cnt_rx <= cnt_rx + 1'b1;
        lat_sum <= sum_wide[CNT_W] ? CMAX : sum_wide[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = cnt_inj;
      2'd1:    rd_data = cnt_rx;
      2'd2:    rd_data = lat_sum;
      default: rd_data = '0;
    endcase
  end

  p_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_inj >= $past(cnt_inj)) && (cnt_rx >= $past(cnt_rx)) && (lat_sum >= $past(lat_sum)));

  p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !inj_valid);

  p_stamp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && q_full && !clr) |=> pend && $stable(inj_stamp));

  p_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_period == '0 && !pend) |=> !pend);

  p_misroute_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_dest != node_id && !clr) |=> rx_misroute && $stable(cnt_rx) && $stable(lat_sum));
endmodule

// File: tb/test_traffic_endpoint.sv
module test_traffic_endpoint;
  logic clk = 0, rst_n = 0, clr = 0, tick = 0, q_full = 0;
  logic rx_valid = 0;
  logic [31:0] sim_time = 0, rx_stamp = 0;
  logic [3:0] node_id = 4'd5, cfg_dest = 4'd9, rx_dest = 0;
  logic [15:0] cfg_period = 0;
  logic [1:0] rd_sel = 0;
  logic inj_valid, rx_misroute;
  logic [3:0] inj_dest;
  logic [31:0] inj_stamp, rd_data;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  traffic_endpoint i_traffic_endpoint (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] s, input string req, input logic [31:0] exp);
    rd_sel = s; #1; chk(req, rd_data, exp);
  endtask

  task automatic do_clr();
    clr = 1; step(); clr = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step(); rst_n = 1; step();
    rd(0, "R1", 0); rd(1, "R1", 0); rd(2, "R1", 0);
    chk("R1", inj_valid, 0);
    rd(3, "R10", 0);

    // R2/R3 sweep over periods
    for (int p = 1; p <= 5; p++) begin
      int exp_inj;
      cfg_period = 16'(p); do_clr();
      exp_inj = 0;
      for (int i = 1; i <= 6 * p + 1; i++) begin
        sim_time = 32'(1000 * p + 7 * i); tick = 1; step(); tick = 0;
        chk("R2", inj_valid, 1'((i % p) == 0));
        if (i % p == 0) begin
          exp_inj++;
          chk("R3", inj_stamp, 32'(1000 * p + 7 * i));
          chk("R2", inj_dest, cfg_dest);
        end
      end
      step();
      chk("R2", inj_valid, 0);
      rd(0, "R2", 32'(exp_inj));
    end

    // R4 period zero
    cfg_period = 0; do_clr();
    for (int i = 0; i < 20; i++) begin
      tick = 1; sim_time = 32'(i); step(); tick = 0;
      if (inj_valid) chk("R4", inj_valid, 0);
    end
    chk("R4", inj_valid, 0);
    rd(0, "R4", 0);

    // R5 full holds stamp, second generation dropped
    cfg_period = 2; do_clr(); q_full = 1;
    for (int i = 1; i <= 5; i++) begin
      sim_time = 32'(500 + i); tick = 1; step(); tick = 0;
      chk("R5", inj_valid, 0);
    end
    chk("R5", inj_stamp, 502);
    rd(0, "R5", 0);
    q_full = 0; #1;
    chk("R5", inj_valid, 1);
    step();
    chk("R5", inj_valid, 0);
    rd(0, "R5", 1);
    cfg_period = 0;

    // R6/R7 receptions
    do_clr();
    for (int k = 0; k < 8; k++) begin
      rx_valid = 1; rx_dest = node_id;
      sim_time = 32'(100 + 3 * k); rx_stamp = 32'(100 + 3 * k - k);
      step();
    end
    rx_valid = 0;
    rd(1, "R6", 8); rd(2, "R7", 28);
    rx_valid = 1; rx_dest = node_id; rx_stamp = 0; sim_time = 6; step(); rx_valid = 0;
    rd(2, "R7", 34);

    // R8 misroute
    rx_valid = 1; rx_dest = 4'd3; rx_stamp = 0; sim_time = 50; step(); rx_valid = 0;
    chk("R8", rx_misroute, 1);
    rd(1, "R8", 9); rd(2, "R8", 34);
    step();
    chk("R8", rx_misroute, 0);

    // R9 saturation of latency sum
    do_clr();
    for (int k = 0; k < 2; k++) begin
      rx_valid = 1; rx_dest = node_id; rx_stamp = 0; sim_time = 32'hF000_0000; step();
    end
    rx_valid = 0;
    rd(2, "R9", 32'hFFFF_FFFF);
    rd(1, "R10", 2);
    rd(3, "R10", 0);
    do_clr();
    rd(2, "R1", 0); rd(1, "R1", 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule